// File: doc/BRIEF.md
# Weight-Stationary Systolic FIR Chain

This block computes a one-dimensional convolution with a chain of multiply-accumulate elements, each of which keeps one signed weight in a local register. Before a stream starts, the weights are written one at a time from a global weight source. The write index advances by element and wraps around. While the stream runs, the weights never move. Input samples enter the first element and travel down the chain through two registers per element. Each element adds its own product to the partial sum it receives from its left neighbour and hands the total to its right neighbour.

The chain moves one step for every sample accepted on the input handshake. It produces exactly one finished dot product per step once the sliding window is fully populated. If the consumer holds off the output, the whole chain freezes and nothing is lost. A weight write is refused while a sample is being offered or a result is still waiting. A refused write raises a sticky error flag. An accepted write starts a new stream, so the priming count begins again from zero.

Top module: `wsmac_chain`

## Requirements
- R1: After reset, out_valid and load_err are 0 and in_ready is 1.
- R2: An accepted weight write stores wl_data into the element whose index equals the write counter. The counter starts at 0 after reset, increments on each accepted write, and wraps from NUM_PE-1 back to 0, so a fifth write with NUM_PE=4 replaces the weight of element 0.
- R3: Let x(i) be the i-th sample accepted since the last accepted weight write, and let w(j) be the weight of element j. The result emitted for window m is the sum over j = 0..NUM_PE-1 of w(j)*x(m-j). Results leave in order of m.
- R4: The first 2*NUM_PE-2 accepted samples of a stream produce no result. Every later accepted sample produces exactly one result, and out_valid rises on the clock edge that accepts it.
- R5: Weights and samples are two's-complement signed 8-bit values, including -128. Products are sign-extended and summed modulo 2^ACC_W (24 bits by default) with no saturation.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_valid and out_data keep their values on the next cycle.
- R7: A weight write offered while in_valid or out_valid is 1 changes no weight, and load_err becomes 1 on the next cycle. load_err then stays 1 until reset.
- R8: An accepted weight write restarts priming, so the next 2*NUM_PE-2 accepted samples again produce no result.
- R9: When a result is taken (out_valid and out_ready are 1) and no sample is accepted in that cycle, out_valid is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wl_valid | input | 1 | Weight write strobe |
| wl_data | input | DW | Signed weight for the element selected by the write counter |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Chain can take a sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Finished dot product present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ACC_W | Signed dot product, wrapped |
| load_err | output | 1 | Sticky flag: a weight write was refused |

## Verification
Two things can land on one clock edge: a weight-write strobe and a sample offer, or a weight-write strobe and a result still waiting behind a stalled consumer. The random phase raises the write strobe together with random input and output handshakes to provoke both cases. The bench decides whether each write was accepted using the same rule the requirements give. It then checks that load_err matches this decision. It also checks that the results which follow still come from the weights held before the refused write. Stalls are judged by requiring that out_data and out_valid stay frozen in the cycle after a refused output handshake.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

   // index width that never collapses to zero bits
   function automatic int idx_width(input int count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/wsmac_pe.sv
module wsmac_pe #(
   parameter int DW    = 8,
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    w_we,
   input  logic signed [DW-1:0]    w_in,
   input  logic                    step,
   input  logic signed [DW-1:0]    x_in,
   input  logic signed [ACC_W-1:0] ps_in,
   output logic signed [ACC_W-1:0] ps_out
);
   localparam int PW = 2 * DW;

   logic signed [DW-1:0]    w_q;
   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] prod_ext;
   logic signed [ACC_W-1:0] ps_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_we) w_q <= w_in;
   end

   always_comb begin
      prod     = w_q * x_in;
      prod_ext = ACC_W'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ps_q <= '0;
      else if (step) ps_q <= ps_in + prod_ext;
   end

   assign ps_out = ps_q;

   // R6
   psum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ps_out));

endmodule

// File: rtl/wsmac_loader.sv
module wsmac_loader #(
   parameter int NUM_PE = 4,
   localparam int IW    = wsmac_pkg::idx_width(NUM_PE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wl_valid,
   input  logic          busy,
   output logic          load_ok,
   output logic [IW-1:0] idx,
   output logic          load_err
);
   localparam logic [IW-1:0] LAST_IDX = IW'(NUM_PE - 1);

   assign load_ok = wl_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx <= '0;
      else if (load_ok) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                load_err <= 1'b0;
      else if (wl_valid && busy) load_err <= 1'b1;
   end

   // R2
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);
   // R7
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wl_valid && busy |=> load_err);
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> load_err);

endmodule

// File: rtl/wsmac_chain.sv
module wsmac_chain #(
   parameter int NUM_PE = 4,
   parameter int DW     = 8,
   parameter int ACC_W  = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wl_valid,
   input  logic signed [DW-1:0]    wl_data,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic signed [DW-1:0]    in_data,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic signed [ACC_W-1:0] out_data,
   output logic                    load_err
);
   localparam int IW    = wsmac_pkg::idx_width(NUM_PE);
   localparam int PRIME = 2 * NUM_PE - 2;
   localparam int CW    = wsmac_pkg::idx_width(PRIME + 1);
   localparam int XD    = (NUM_PE > 1) ? PRIME : 1;
   localparam logic [CW-1:0] PRIME_C = CW'(PRIME);

   if (NUM_PE < 1)      $error("NUM_PE must be at least 1");
   if (DW < 2)          $error("DW must be at least 2");
   if (ACC_W < 2 * DW)  $error("ACC_W must hold a full product");

   logic          step, busy, load_ok;
   logic [IW-1:0] idx;
   logic [CW-1:0] cnt;

   assign in_ready = !out_valid || out_ready;
   assign step     = in_valid && in_ready;
   assign busy     = in_valid || out_valid;

   wsmac_loader #(.NUM_PE(NUM_PE)) loader_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wl_valid (wl_valid),
      .busy     (busy),
      .load_ok  (load_ok),
      .idx      (idx),
      .load_err (load_err)
   );

   // sample delay line: two registers per element after the first
   logic signed [DW-1:0] xd [XD];

   if (NUM_PE > 1) begin : g_xline
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < XD; i++) xd[i] <= '0;
         end else if (step) begin
            xd[0] <= in_data;
            for (int i = 1; i < XD; i++) xd[i] <= xd[i-1];
         end
      end
   end else begin : g_noline
      assign xd[0] = '0;
   end

   logic signed [ACC_W-1:0] ps [NUM_PE];

   for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
      logic signed [DW-1:0]    x_k;
      logic signed [ACC_W-1:0] ps_k;
      if (k == 0) begin : g_head
         assign x_k  = in_data;
         assign ps_k = '0;
      end else begin : g_body
         assign x_k  = xd[2*k-1];
         assign ps_k = ps[k-1];
      end
      wsmac_pe #(.DW(DW), .ACC_W(ACC_W)) pe_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .w_we   (load_ok && (idx == IW'(k))),
         .w_in   (wl_data),
         .step   (step),
         .x_in   (x_k),
         .ps_in  (ps_k),
         .ps_out (ps[k])
      );
   end

   assign out_data = ps[NUM_PE-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         out_valid <= 1'b0;
      end else if (load_ok) begin
         cnt <= '0;
      end else if (step) begin
         out_valid <= (cnt == PRIME_C);
         if (cnt != PRIME_C) cnt <= cnt + 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   // R9
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !in_valid |=> !out_valid);
   // R4
   rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));
   // R8
   load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |=> !out_valid);

endmodule

// File: tb/wsmac_chain_tb_top.sv
`timescale 1ns/1ps
module wsmac_chain_tb_top;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wl_valid = 1'b0;
   logic signed [7:0] wl_data = '0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic signed [7:0] in_data = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic signed [23:0] out_data;
   logic load_err;

   always #4 clk = ~clk;

   wsmac_chain #(.NUM_PE(N), .DW(8), .ACC_W(24)) dut_i (
      .clk(clk), .rst_n(rst_n), .wl_valid(wl_valid), .wl_data(wl_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .load_err(load_err));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic signed [7:0]  w_m [N];
   int                 widx = 0;
   bit                 err_m = 0;
   logic signed [7:0]  hist [1024];
   int                 nsamp = 0;
   logic signed [23:0] exp_q [$];
   bit                 prev_stall = 0;
   logic signed [23:0] prev_data = '0;

   function automatic logic signed [23:0] fir_at(input int m);
      logic signed [23:0] acc = '0;
      for (int j = 0; j < N; j++)
         acc = acc + 24'(int'(w_m[j]) * int'(hist[(m - j) % 1024]));
      return acc;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // one cycle: called at a falling edge, returns at the next falling edge
   task automatic tick(input bit iv, input logic signed [7:0] id, input bit ordy,
                       input bit wv, input logic signed [7:0] wd);
      if (prev_stall) begin
         check(out_valid == 1'b1, "R6 held valid", out_valid, 1);
         check(out_data == prev_data, "R6 held data", out_data, prev_data);
      end
      check(load_err == err_m, "R7 load_err", load_err, err_m);
      check(out_valid == (exp_q.size() > 0), "R4/R9 out_valid", out_valid, exp_q.size() > 0);
      in_valid = iv; in_data = id; out_ready = ordy; wl_valid = wv; wl_data = wd;
      #1;
      check(in_ready == (!out_valid || ordy), "R6 in_ready", in_ready, !out_valid || ordy);
      prev_stall = out_valid && !ordy;
      prev_data  = out_data;
      if (out_valid && ordy && exp_q.size() > 0) begin
         logic signed [23:0] e = exp_q.pop_front();
         check(out_data == e, "R3/R5 result", out_data, e);
      end
      if (wv && !iv && !out_valid) begin
         w_m[widx] = wd;                         // R2 serial write by index
         widx = (widx + 1) % N;
         nsamp = 0;                              // R8 restart
      end else if (wv) begin
         err_m = 1;                              // R7 refused
      end
      if (iv && in_ready) begin
         hist[nsamp % 1024] = id;
         if (nsamp >= 2*N - 2) exp_q.push_back(fir_at(nsamp - N + 1));
         nsamp++;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_w(input logic signed [7:0] w);
      tick(0, 0, 1, 1, w);
   endtask

   task automatic drain();
      for (int i = 0; i < 4; i++) tick(0, 0, 1, 0, 0);
   endtask

   initial begin
      for (int j = 0; j < N; j++) w_m[j] = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(out_valid == 0, "R1 out_valid", out_valid, 0);
      check(load_err == 0, "R1 load_err", load_err, 0);
      check(in_ready == 1, "R1 in_ready", in_ready, 1);

      // R2 R3 R4: directed weights and a ramp
      load_w(1); load_w(2); load_w(3); load_w(4);
      for (int i = 0; i < 12; i++) tick(1, 8'(i + 1), 1, 0, 0);
      drain();

      // R2: five writes wrap onto element 0
      load_w(5); load_w(-6); load_w(7); load_w(-8); load_w(9);
      for (int i = 0; i < 10; i++) tick(1, 8'(i * 13 - 40), 1, 0, 0);
      drain();

      // R5: extreme signed values
      for (int j = 0; j < N; j++) load_w(-128);
      for (int i = 0; i < 12; i++) tick(1, (i % 3 == 0) ? 8'sd127 : -8'sd128, 1, 0, 0);
      drain();
      for (int j = 0; j < N; j++) load_w(127);
      for (int i = 0; i < 10; i++) tick(1, -8'sd128, 1, 0, 0);
      drain();

      // R6: directed stall
      for (int i = 0; i < 8; i++) tick(1, 8'(i * 7), 1, 0, 0);
      for (int i = 0; i < 3; i++) tick(1, 8'sd99, 0, 0, 0);
      tick(0, 0, 1, 0, 0);
      drain();

      // random weights and streams, clean handshakes
      for (int j = 0; j < N; j++) load_w(8'($urandom));
      for (int i = 0; i < 300; i++)
         tick($urandom % 4 != 0, 8'($urandom), $urandom % 3 != 0, 0, 0);
      drain();

      // R7: strobe colliding with a sample, then refused writes mixed in
      tick(1, 8'sd5, 1, 1, 8'sd77);
      for (int i = 0; i < 300; i++)
         tick($urandom % 2 == 0, 8'($urandom), $urandom % 3 != 0,
              $urandom % 9 == 0, 8'($urandom));
      drain();
      check(load_err == 1, "R7 sticky", load_err, 1);

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule